// File: doc/BRIEF.md
# Alternating Two-Line Barrier Unit

This block synchronises a fixed group of processors at barrier points. Each processor owns one arrival input and one release output. Internally, each processor drives two shared combining lines. Each line is the AND of one drive bit from every processor, which models an open-collector wired-AND. One line serves even-numbered barrier episodes and the other serves odd-numbered ones. A processor that reaches a barrier raises its drive on the line for its current parity and then stalls. It is released once that line reads high, and on release it flips its parity.

Each processor is controlled by a two-state machine. In state `ST_RUN` the processor is executing. The transition ARRIVE (an `arrive` pulse seen in `ST_RUN`) moves it to `ST_WAIT`. In `ST_WAIT` the transition RELEASE (the line for the current parity reads high) returns it to `ST_RUN` and toggles the parity. Because consecutive barriers use different lines, a processor may arrive at the next barrier in the cycle right after its release. It does not have to wait for the previous line to clear.

Top module: `parity_barrier`

## Requirements
- R1: After reset every processor is in `ST_RUN` with even parity, all drives are low, `release_o` is all zeros and `line_o` is 2'b00.
- R2: `line_o[0]` is the even line and `line_o[1]` is the odd line. Each is high only when every one of the N drive bits for that line is high. An arrival accepted at a clock edge raises the processor's drive on its current-parity line and clears its drive on the other line.
- R3: When the last processor's arrival is registered at an edge, `release_o` goes to all ones in the clock cycle that follows that edge, for every processor in the same cycle.
- R4: No processor is released unless all N processors are waiting on the same barrier. This holds across at least four consecutive barriers.
- R5: A release is a one-cycle pulse. Every processor's parity toggles on release, and the first barrier after reset uses the even line.
- R6: An `arrive` pulse from a processor already in `ST_WAIT` is ignored. Its drives, its state and the lines do not change.
- R7: An arrival in the cycle right after release is accepted on the other line. No processor is released from it until all N have arrived again.
- R8: After release, a processor's drive on the line it used stays high until its next arrival, so that line remains high until the first processor enters the following barrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | N_PROC | Per-processor barrier arrival strobe |
| release_o | output | N_PROC | Per-processor one-cycle release pulse |
| line_o | output | 2 | Combined lines: bit 0 even, bit 1 odd |

## Verification
The hardest case to reach is a processor re-arriving at the next barrier while a slower peer has not yet been released. A second case is a waiting processor strobing `arrive` again. Random stimulus rarely lines up either one, so directed sequences hold `arrive` high across several back-to-back barriers and re-pulse a waiting processor. Long random runs then compare every cycle against a bench model and count completed barriers.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    localparam int LINES = 2;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } agent_state_t;
endpackage

// File: rtl/barrier_agent.sv
module barrier_agent
    import barrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrive_i,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] drive_o,
    output logic             release_o
);
    agent_state_t     state_q, state_d;
    logic             par_q, par_d;
    logic [LINES-1:0] drv_q, drv_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            par_q   <= 1'b0;
            drv_q   <= '0;
        end else begin
            state_q <= state_d;
            par_q   <= par_d;
            drv_q   <= drv_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        par_d   = par_q;
        drv_d   = drv_q;
        unique case (state_q)
            ST_RUN: begin
                if (arrive_i) begin
                    state_d = ST_WAIT;
                    drv_d   = par_q ? 2'b10 : 2'b01;
                end
            end
            ST_WAIT: begin
                if (line_i[par_q]) begin
                    state_d = ST_RUN;
                    par_d   = ~par_q;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        drive_o   = drv_q;
        release_o = (state_q == ST_WAIT) && line_i[par_q];
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);
    // R5
    parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (par_q != $past(par_q)));
    // R2
    one_line_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_o));
    // R6
    wait_ignores_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && arrive_i && !release_o) |=> ($stable(drive_o) && state_q == ST_WAIT));
endmodule

// File: rtl/barrier_combine.sv
module barrier_combine
    import barrier_pkg::*;
#(
    parameter int N_PROC = 4
) (
    input  logic [LINES-1:0][N_PROC-1:0] drv_i,
    output logic [LINES-1:0]             line_o
);
    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign line_o[l] = &drv_i[l];
    end
endmodule

// File: rtl/parity_barrier.sv
module parity_barrier
    import barrier_pkg::*;
#(
    parameter int N_PROC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PROC-1:0] arrive,
    output logic [N_PROC-1:0] release_o,
    output logic [LINES-1:0]  line_o
);
    logic [LINES-1:0]             agent_drv [N_PROC];
    logic [LINES-1:0][N_PROC-1:0] drv_mat;

    for (genvar g = 0; g < N_PROC; g++) begin : g_agent
        barrier_agent u_agent (
            .clk       (clk),
            .rst_n     (rst_n),
            .arrive_i  (arrive[g]),
            .line_i    (line_o),
            .drive_o   (agent_drv[g]),
            .release_o (release_o[g])
        );
        for (genvar l = 0; l < LINES; l++) begin : g_map
            assign drv_mat[l][g] = agent_drv[g][l];
        end
    end

    barrier_combine #(.N_PROC(N_PROC)) u_combine (
        .drv_i  (drv_mat),
        .line_o (line_o)
    );

    // R3
    all_or_none_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> (&release_o));
    // R7
    lines_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_o != 2'b11);
endmodule

// File: tb/parity_barrier_test.sv
module parity_barrier_test;
    localparam int N = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] arrive;
    logic [N-1:0] release_o;
    logic [1:0]   line_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int barriers = 0;
    bit done = 1'b0;

    bit       m_wait [N];
    bit       m_par  [N];
    bit [1:0] m_drv  [N];

    parity_barrier #(.N_PROC(N)) uut (
        .clk(clk), .rst_n(rst_n), .arrive(arrive),
        .release_o(release_o), .line_o(line_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [1:0] exp_lines();
        logic [1:0] r = 2'b11;
        for (int i = 0; i < N; i++) r &= m_drv[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_release();
        logic [N-1:0] r = '0;
        logic [1:0] ln = exp_lines();
        for (int i = 0; i < N; i++) r[i] = m_wait[i] && ln[m_par[i]];
        return r;
    endfunction

    function automatic int waiting_count();
        int c = 0;
        for (int i = 0; i < N; i++) c += m_wait[i];
        return c;
    endfunction

    // called at a negedge: check outputs, drive next arrivals, advance model
    task automatic step(input logic [N-1:0] arr);
        logic [N-1:0] er;
        er = exp_release();
        chk("R3 release", release_o, er);
        chk("R2 lines", line_o, exp_lines());
        if (er != 0) begin
            chk("R4 all arrived before release", waiting_count(), N);
            barriers++;
        end
        arrive = arr;
        for (int i = 0; i < N; i++) begin
            if (m_wait[i] && er[i]) begin
                m_wait[i] = 1'b0;
                m_par[i]  = ~m_par[i];
            end else if (!m_wait[i] && arr[i]) begin
                m_wait[i] = 1'b1;
                m_drv[i]  = m_par[i] ? 2'b10 : 2'b01;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        rst_n  = 1'b0;
        arrive = '0;
        for (int i = 0; i < N; i++) begin
            m_wait[i] = 1'b0; m_par[i] = 1'b0; m_drv[i] = 2'b00;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 release", release_o, 0);
        chk("R1 lines", line_o, 2'b00);

        // all arrive together: first barrier uses even line
        step(4'hF);
        chk("R3 joint release", release_o, 4'hF);
        chk("R5 even line first", line_o, 2'b01);
        step(4'h0);
        chk("R5 pulse one cycle", release_o, 4'h0);
        chk("R8 even line held", line_o, 2'b01);

        // staggered odd barrier with re-arrival while waiting
        step(4'h1);
        chk("R8 even line drops on next arrival", line_o, 2'b00);
        step(4'h0);
        step(4'h2);
        step(4'h1);
        chk("R6 re-arrive ignored", {release_o, line_o}, {4'h0, 2'b00});
        step(4'h4);
        chk("R4 not released with three", release_o, 4'h0);
        step(4'h8);
        chk("R3 odd release", release_o, 4'hF);
        chk("R5 odd line", line_o, 2'b10);

        // arrive held high: back-to-back barriers
        step(4'hF);
        step(4'hF);
        chk("R7 immediate re-entry even", {release_o, line_o}, {4'hF, 2'b01});
        step(4'hF);
        step(4'hF);
        chk("R7 immediate re-entry odd", {release_o, line_o}, {4'hF, 2'b10});

        // one straggler while others hold arrive high
        step(4'h7);
        step(4'h7);
        step(4'h7);
        chk("R7 wait for straggler", release_o, 4'h0);
        step(4'h8);
        chk("R7 straggler completes", release_o, 4'hF);

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] a;
            for (int i = 0; i < N; i++) a[i] = ($urandom % 3) == 0;
            step(a);
        end
        step(4'h0);
        checks++;
        if (barriers < 4) begin
            errors++;
            $display("FAIL R4 barrier count: act=%0d exp>=4", barriers);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule